// File: doc/BRIEF.md
# Group-Bypass Binary Adder

This block adds two unsigned operands of `WIDTH` bits and a single carry-in bit. It returns a `WIDTH`-bit sum and a carry-out. It is purely combinational: there is no clock, no reset and no internal state. The operands are split into `WIDTH / GROUP` equal slices, and the slices are chained through their carries.

Inside a slice, the carry ripples from bit to bit in the usual way. Each slice also forms one slice-wide propagate term, which is the AND of the bit propagates of all its bits. When that term is high, the carry arriving at the slice is steered directly to its carry output through a two-way selector. The selector skips the internal ripple, so a carry that crosses many slices passes one selector per slice instead of every bit.

The block is meant for datapaths that need a narrow but faster alternative to a plain ripple adder. `GROUP` must divide `WIDTH` evenly; any other setting is rejected at elaboration.

Top module: `csk_adder`

## Requirements
- R1: For every input, `{carry_out, sum_out}` equals `op_a + op_b + carry_in`, computed as an unsigned value of `WIDTH+1` bits.
- R2: For each bit i, the bit generate is `op_a[i] & op_b[i]` and the bit propagate is `op_a[i] ^ op_b[i]`. `sum_out[i]` is the bit propagate XOR the carry into bit i.
- R3: When at least one bit propagate inside a slice is 0, that slice's carry output is the carry produced by its own internal ripple.
- R4: When every bit propagate inside a slice is 1, that slice's carry output equals the carry into the slice.
- R5: Slice 0 (bits `GROUP-1` down to 0) receives `carry_in`. Slice j receives the carry output of slice j-1. So a carry generated in a low slice reaches all higher bits across slices that are fully propagating.
- R6: `carry_out` is the carry output of the most significant slice.
- R7: With `op_b == ~op_a`, every bit propagates. Then `carry_in = 1` gives `sum_out = 0` and `carry_out = 1`, and `carry_in = 0` gives all ones and `carry_out = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
Embedded checks are evaluated whenever the inputs change:
- each bit's sum parity;
- the selector choosing the bypassed carry when the slice fully propagates;
- the selector choosing the rippled carry otherwise;
- the whole-word total against an arithmetic add.

Whether the carry actually travels across slice boundaries can only be shown by the bench's scenarios. These are a carry born at the top of slice 0 that runs through fully propagating slices, the all-propagate pattern with both carry-in values, and the limits of the operand range.

// File: rtl/csk_pkg.sv
// Package csk_pkg
// Shared helpers for the group-bypass adder. Assumes unsigned integer
// parameters supplied by the instantiating module.
package csk_pkg;

    // Number of slices for a given word and slice width.
    function automatic int unsigned slice_count(input int unsigned w, input int unsigned g);
        return w / g;
    endfunction

    // True when the slice width tiles the word exactly.
    function automatic bit tiles_evenly(input int unsigned w, input int unsigned g);
        return (g != 0) && ((w % g) == 0);
    endfunction

endpackage

// File: rtl/csk_bit_cell.sv
// Module csk_bit_cell
// One-bit full adder written in generate/propagate form. Produces the bit
// propagate for the slice-wide AND, the sum bit and the rippled carry.
// Assumes nothing beyond single-bit inputs.
module csk_bit_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic c_in,
    output logic prop,
    output logic sum,
    output logic c_out
);

    logic gen;

    // Form generate and propagate, then sum and carry from them.
    always_comb begin
        gen   = bit_a & bit_b;
        prop  = bit_a ^ bit_b;
        sum   = prop ^ c_in;
        c_out = gen | (c_in & prop);
    end

    // Sum bit must be the parity of its three inputs.
    always_comb begin
        AST_SUM_PARITY: assert ((sum == (bit_a ^ bit_b ^ c_in)) || $isunknown({bit_a, bit_b, c_in})); // R2
    end

endmodule

// File: rtl/csk_skip_mux.sv
// Module csk_skip_mux
// Two-way carry selector at the top of a slice. Passes the carry into the
// slice when the whole slice propagates, otherwise the slice's own ripple
// carry. Assumes the select is the AND of all bit propagates of the slice.
module csk_skip_mux (
    input  logic slice_prop,
    input  logic bypass_carry,
    input  logic ripple_carry,
    output logic slice_carry
);

    // Select the bypassed carry only for a fully propagating slice.
    always_comb begin
        slice_carry = slice_prop ? bypass_carry : ripple_carry;
    end

endmodule

// File: rtl/csk_slice.sv
// Module csk_slice
// One slice of SLICE_W bits. Ripples internally, forms the slice-wide
// propagate and drives its carry output through the bypass selector.
// Assumes SLICE_W >= 1.
module csk_slice #(
    parameter int unsigned SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_in,
    input  logic [SLICE_W-1:0] b_in,
    input  logic               c_in,
    output logic [SLICE_W-1:0] s_out,
    output logic               c_out
);

    logic [SLICE_W:0]   chain;
    logic [SLICE_W-1:0] bit_prop;
    logic               all_prop;

    // Carry into the lowest bit of the slice.
    always_comb begin
        chain[0] = c_in;
    end

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        csk_bit_cell u_cell (
            .bit_a (a_in[i]),
            .bit_b (b_in[i]),
            .c_in  (chain[i]),
            .prop  (bit_prop[i]),
            .sum   (s_out[i]),
            .c_out (chain[i+1])
        );
    end

    // Slice-wide propagate: every bit passes its carry.
    always_comb begin
        all_prop = &bit_prop;
    end

    csk_skip_mux u_skip (
        .slice_prop   (all_prop),
        .bypass_carry (c_in),
        .ripple_carry (chain[SLICE_W]),
        .slice_carry  (c_out)
    );

    // Selector behaviour relative to the ripple and the incoming carry.
    always_comb begin
        if (!$isunknown({a_in, b_in, c_in})) begin
            AST_SKIP_TAKEN: assert (!all_prop || (c_out == c_in));              // R4
            AST_RIPPLE_KEPT: assert (all_prop || (c_out == chain[SLICE_W]));   // R3
        end
    end

endmodule

// File: rtl/csk_adder.sv
// Module csk_adder
// WIDTH-bit unsigned adder built from WIDTH/GROUP bypass slices chained
// through their carries. Combinational, no clock or reset.
// Assumes GROUP divides WIDTH; otherwise elaboration stops.
module csk_adder #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned GROUP = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    import csk_pkg::*;

    localparam int unsigned NUM_SLICES = slice_count(WIDTH, GROUP);

    if (!tiles_evenly(WIDTH, GROUP)) begin : g_bad_cfg
        $error("csk_adder: GROUP must divide WIDTH");
    end

    logic [NUM_SLICES:0] link;

    // Word carry-in enters the lowest slice.
    always_comb begin
        link[0] = carry_in;
    end

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        csk_slice #(.SLICE_W(GROUP)) u_slice (
            .a_in  (op_a[s*GROUP +: GROUP]),
            .b_in  (op_b[s*GROUP +: GROUP]),
            .c_in  (link[s]),
            .s_out (sum_out[s*GROUP +: GROUP]),
            .c_out (link[s+1])
        );
    end

    // Top slice's carry output is the word carry-out.
    always_comb begin
        carry_out = link[NUM_SLICES];
    end

    // Whole-word result against an arithmetic add.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            AST_WORD_TOTAL: assert ({carry_out, sum_out} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})); // R1
        end
    end

endmodule

// File: tb/csk_adder_tb.sv
module csk_adder_tb_top;

    localparam int unsigned WIDTH      = 32;
    localparam int unsigned GROUP      = 4;
    localparam time         CLK_PERIOD = 10;

    logic             clk;
    logic             rst_n;
    logic [WIDTH-1:0] op_a;
    logic [WIDTH-1:0] op_b;
    logic             carry_in;
    logic [WIDTH-1:0] sum_out;
    logic             carry_out;

    int n_checks;
    int n_fails;
    logic [WIDTH:0] exp_q[$];

    csk_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a vector at the falling edge, queue the behavioural total, compare
    // a quarter period later.
    task automatic apply(input string req, input logic [WIDTH-1:0] a,
                         input logic [WIDTH-1:0] b, input logic ci);
        logic [WIDTH:0] e;
        @(negedge clk);
        op_a = a;
        op_b = b;
        carry_in = ci;
        exp_q.push_back({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci});
        #(CLK_PERIOD/4);
        e = exp_q.pop_front();
        check(req, {carry_out, sum_out}, e);
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        rst_n    = 1'b0;
        op_a     = '0;
        op_b     = '0;
        carry_in = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Quiet state: zero inputs give zero outputs (R1).
        apply("R1 zero", '0, '0, 1'b0);

        // All-propagate pattern, both carry-in values (R7, R4).
        apply("R7 allprop ci1", 32'hA5C3_0F96, ~32'hA5C3_0F96, 1'b1);
        check("R7 sum zero", {1'b0, sum_out}, '0);
        check("R7 cout one", {{WIDTH{1'b0}}, carry_out}, {{WIDTH{1'b0}}, 1'b1});
        apply("R7 allprop ci0", 32'h1234_5678, ~32'h1234_5678, 1'b0);
        check("R7 sum ones", {1'b0, sum_out}, {1'b0, {WIDTH{1'b1}}});

        // Carry born at bit 3 (top of slice 0), then slices 1..7 fully
        // propagate: the carry crosses every boundary (R5, R6, R4).
        apply("R5 cross", 32'hFFFF_FFF8, 32'h0000_0008, 1'b0);
        check("R6 cout", {{WIDTH{1'b0}}, carry_out}, {{WIDTH{1'b0}}, 1'b1});

        // carry_in alone travels through every slice (R5).
        apply("R5 cin ripple", 32'hFFFF_FFFF, '0, 1'b1);

        // Slice with a killed bit absorbs the carry locally (R3).
        apply("R3 kill", 32'h0000_00F0, 32'h0000_0007, 1'b1);
        apply("R3 gen in slice", 32'h0000_0090, 32'h0000_0090, 1'b0);

        // Limits of the operand range (R1, R2).
        apply("R1 max", '1, '1, 1'b1);
        apply("R2 alt", 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);

        // Random vectors (R1, R2).
        for (int i = 0; i < 300; i++) begin
            apply("R1 random", $urandom, $urandom, 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule